// File: doc/BRIEF.md
# Doorbell Mailbox Register Bank

This block is a mailbox between one physical function (PF) and a parameterised number of virtual functions (VFs). Each function owns two 64-bit words in each direction: a message word (select 0) and a data word (select 1). Each side has a simple request port carrying a function index, a select, a write flag and write data. A read returns the word the other side last wrote, so the two sides never overwrite each other's words.

A sender first writes the data word and then the message word. Only the write to the message word rings a doorbell. When a VF writes, bit v of the PF status vector is set and the PF interrupt is raised. The PF acknowledges by writing ones to status bits. When the PF writes, the per-function VF doorbell bit is set, and each VF clears only its own bit. Reads never change a doorbell. Requests to a function index at or above the function count have no effect.

Top module: `doorbell_mailbox_bank`

## Requirements
- R1: A write with select 0 (message) or 1 (data) to an in-range function stores the 64-bit word at the clock edge. A read request returns, on the registered read data one cycle later, the word that the other side holds for that function. The read sees the value from before any write in the same cycle. All words and the read data reset to zero, and the read data holds its value between reads.
- R2: A VF write to the message word of in-range function v sets PF status bit v. The PF interrupt is high from the next cycle.
- R3: A write to a data word, from either side, sets no doorbell or status bit.
- R4: A PF read with select 2 returns the status vector, with bit v in bit position v and zeros above bit NUM_FN-1.
- R5: A PF write with select 2 clears exactly the status bits at which the write data holds a 1, whatever the function index. All other status bits are unchanged.
- R6: The PF interrupt is high while any status bit is set. It falls only after every bit has been cleared.
- R7: Reads on either port leave the status vector and the VF doorbell bits unchanged.
- R8: When a doorbell set and a clear hit the same bit in the same cycle, the bit ends set. This holds in both directions.
- R9: A PF write to the message word of function v sets vf_irq[v]. A VF read with select 2 returns its own doorbell bit in bit 0. A VF write with select 2 and data bit 0 equal to 1 clears only its own doorbell bit. With bit 0 equal to 0, the write does nothing.
- R10: A request whose function index is NUM_FN or above is ignored, and so is one with select 3. Writes change nothing, and reads return zero. The index limit does not apply to PF status accesses with select 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_req | input | 1 | PF access strobe |
| pf_we | input | 1 | PF write (1) or read (0) |
| pf_fn | input | FNW | Function index addressed by the PF |
| pf_sel | input | 2 | 0 message, 1 data, 2 status, 3 reserved |
| pf_wdata | input | DW | PF write data |
| pf_rdata | output | DW | PF registered read data |
| pf_irq | output | 1 | PF interrupt, any status bit set |
| vf_req | input | 1 | VF access strobe |
| vf_we | input | 1 | VF write (1) or read (0) |
| vf_fn | input | FNW | Index of the accessing VF |
| vf_sel | input | 2 | 0 message, 1 data, 2 own doorbell, 3 reserved |
| vf_wdata | input | DW | VF write data |
| vf_rdata | output | DW | VF registered read data |
| vf_irq | output | NUM_FN | Per-function doorbell toward the VFs |

## Verification
A stuck or lost status bit shows on pf_irq in the cycle after the event that should have changed it. A wrong word store shows in pf_rdata or vf_rdata one cycle after the next read of that word. The reference model compares both interrupt outputs on every cycle, so a wrong doorbell shows at once. The directed part of the test drives the same-cycle set/clear race, partial clears, own-bit clears on the VF side, and out-of-range indices. A random phase then mixes all access types on both ports.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
    typedef enum logic [1:0] {
        SEL_MSG  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_RSV  = 2'd3
    } mbx_sel_e;
endpackage

// File: rtl/mbx_access_dec.sv
`timescale 1ns/1ps
module mbx_access_dec #(
    parameter int NUM_FN = 16,
    parameter int FNW    = 5
) (
    input  logic              req,
    input  logic              we,
    input  logic [FNW-1:0]    fn,
    input  logic [1:0]        sel,
    output logic [NUM_FN-1:0] fn_hot,
    output logic [NUM_FN-1:0] msg_wr,
    output logic [NUM_FN-1:0] dat_wr,
    output logic              ctl_wr,
    output logic              rd_en,
    output logic              fn_ok
);
    import mbx_pkg::*;

    localparam logic [FNW-1:0] LIMIT = FNW'(NUM_FN);

    mbx_sel_e sel_e;
    assign sel_e  = mbx_sel_e'(sel);
    assign fn_ok  = (fn < LIMIT);
    assign rd_en  = req & ~we;
    assign ctl_wr = req & we & (sel_e == SEL_CTL);

    for (genvar g = 0; g < NUM_FN; g++) begin : g_hot
        assign fn_hot[g] = req & (fn == FNW'(g));
        assign msg_wr[g] = fn_hot[g] & we & (sel_e == SEL_MSG);
        assign dat_wr[g] = fn_hot[g] & we & (sel_e == SEL_DATA);
    end
endmodule

// File: rtl/mbx_word_bank.sv
`timescale 1ns/1ps
module mbx_word_bank #(
    parameter int NUM_FN = 16,
    parameter int DW     = 64,
    parameter int FNW    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_FN-1:0] msg_wr,
    input  logic [NUM_FN-1:0] dat_wr,
    input  logic [DW-1:0]     wdata,
    input  logic [FNW-1:0]    rd_fn,
    input  logic              rd_dat,
    output logic [DW-1:0]     rd_word
);
    logic [DW-1:0] msg_q [NUM_FN];
    logic [DW-1:0] dat_q [NUM_FN];

    for (genvar g = 0; g < NUM_FN; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                msg_q[g] <= '0;
                dat_q[g] <= '0;
            end else begin
                if (msg_wr[g]) msg_q[g] <= wdata;
                if (dat_wr[g]) dat_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_FN; i++) begin
            if (rd_fn == FNW'(i)) rd_word = rd_dat ? dat_q[i] : msg_q[i];
        end
    end
endmodule

// File: rtl/mbx_bell_vec.sv
`timescale 1ns/1ps
module mbx_bell_vec #(
    parameter int NUM_FN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_FN-1:0] set,
    input  logic [NUM_FN-1:0] clr,
    output logic [NUM_FN-1:0] bell
);
    always_ff @(posedge clk) begin
        if (!rst_n) bell <= '0;
        else        bell <= (bell & ~clr) | set;
    end
endmodule

// File: rtl/doorbell_mailbox_bank.sv
`timescale 1ns/1ps
module doorbell_mailbox_bank #(
    parameter int NUM_FN = 16,
    parameter int DW     = 64,
    localparam int FNW   = $clog2(NUM_FN) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_req,
    input  logic              pf_we,
    input  logic [FNW-1:0]    pf_fn,
    input  logic [1:0]        pf_sel,
    input  logic [DW-1:0]     pf_wdata,
    output logic [DW-1:0]     pf_rdata,
    output logic              pf_irq,
    input  logic              vf_req,
    input  logic              vf_we,
    input  logic [FNW-1:0]    vf_fn,
    input  logic [1:0]        vf_sel,
    input  logic [DW-1:0]     vf_wdata,
    output logic [DW-1:0]     vf_rdata,
    output logic [NUM_FN-1:0] vf_irq
);
    import mbx_pkg::*;

    logic [NUM_FN-1:0] pf_hot, pf_msg_wr, pf_dat_wr;
    logic [NUM_FN-1:0] vf_hot, vf_msg_wr, vf_dat_wr;
    logic              pf_ctl_wr, pf_rd_en, pf_fn_ok;
    logic              vf_ctl_wr, vf_rd_en, vf_fn_ok;
    logic [NUM_FN-1:0] pf_status, pf_clr, vf_clr;
    logic [DW-1:0]     up_word, dn_word, pf_rd_nxt, vf_rd_nxt;

    mbx_access_dec #(.NUM_FN(NUM_FN), .FNW(FNW)) u_pf_dec (
        .req(pf_req), .we(pf_we), .fn(pf_fn), .sel(pf_sel),
        .fn_hot(pf_hot), .msg_wr(pf_msg_wr), .dat_wr(pf_dat_wr),
        .ctl_wr(pf_ctl_wr), .rd_en(pf_rd_en), .fn_ok(pf_fn_ok)
    );

    mbx_access_dec #(.NUM_FN(NUM_FN), .FNW(FNW)) u_vf_dec (
        .req(vf_req), .we(vf_we), .fn(vf_fn), .sel(vf_sel),
        .fn_hot(vf_hot), .msg_wr(vf_msg_wr), .dat_wr(vf_dat_wr),
        .ctl_wr(vf_ctl_wr), .rd_en(vf_rd_en), .fn_ok(vf_fn_ok)
    );

    // Words written by the VFs, read by the PF
    mbx_word_bank #(.NUM_FN(NUM_FN), .DW(DW), .FNW(FNW)) u_up_bank (
        .clk(clk), .rst_n(rst_n), .msg_wr(vf_msg_wr), .dat_wr(vf_dat_wr),
        .wdata(vf_wdata), .rd_fn(pf_fn), .rd_dat(pf_sel[0]), .rd_word(up_word)
    );

    // Words written by the PF, read by the VFs
    mbx_word_bank #(.NUM_FN(NUM_FN), .DW(DW), .FNW(FNW)) u_dn_bank (
        .clk(clk), .rst_n(rst_n), .msg_wr(pf_msg_wr), .dat_wr(pf_dat_wr),
        .wdata(pf_wdata), .rd_fn(vf_fn), .rd_dat(vf_sel[0]), .rd_word(dn_word)
    );

    assign pf_clr = pf_ctl_wr ? pf_wdata[NUM_FN-1:0] : '0;
    assign vf_clr = vf_hot & {NUM_FN{vf_ctl_wr & vf_wdata[0]}};

    mbx_bell_vec #(.NUM_FN(NUM_FN)) u_pf_stat (
        .clk(clk), .rst_n(rst_n), .set(vf_msg_wr), .clr(pf_clr), .bell(pf_status)
    );

    mbx_bell_vec #(.NUM_FN(NUM_FN)) u_vf_bell (
        .clk(clk), .rst_n(rst_n), .set(pf_msg_wr), .clr(vf_clr), .bell(vf_irq)
    );

    assign pf_irq = |pf_status;

    always_comb begin
        pf_rd_nxt = '0;
        unique case (mbx_sel_e'(pf_sel))
            SEL_MSG, SEL_DATA: if (pf_fn_ok) pf_rd_nxt = up_word;
            SEL_CTL:           pf_rd_nxt[NUM_FN-1:0] = pf_status;
            SEL_RSV:           pf_rd_nxt = '0;
        endcase
    end

    always_comb begin
        vf_rd_nxt = '0;
        unique case (mbx_sel_e'(vf_sel))
            SEL_MSG, SEL_DATA: if (vf_fn_ok) vf_rd_nxt = dn_word;
            SEL_CTL:           vf_rd_nxt[0] = |(vf_irq & vf_hot);
            SEL_RSV:           vf_rd_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_rdata <= '0;
            vf_rdata <= '0;
        end else begin
            if (pf_rd_en) pf_rdata <= pf_rd_nxt;
            if (vf_rd_en) vf_rdata <= vf_rd_nxt;
        end
    end
endmodule

// File: rtl/mbx_bank_chk.sv
`timescale 1ns/1ps
module mbx_bank_chk #(
    parameter int NUM_FN = 16,
    parameter int DW     = 64,
    parameter int FNW    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pf_req,
    input logic              pf_we,
    input logic [FNW-1:0]    pf_fn,
    input logic [1:0]        pf_sel,
    input logic [DW-1:0]     pf_wdata,
    input logic [DW-1:0]     pf_rdata,
    input logic              pf_irq,
    input logic              vf_req,
    input logic              vf_we,
    input logic [FNW-1:0]    vf_fn,
    input logic [1:0]        vf_sel,
    input logic [DW-1:0]     vf_wdata,
    input logic [NUM_FN-1:0] vf_irq
);
    localparam logic [FNW-1:0] LIMIT = FNW'(NUM_FN);

    logic              up_ring, pf_clear_all, pf_stat_wr, pf_stat_rd, pf_oor_rd;
    logic [NUM_FN-1:0] dn_hot, vf_own_clr;

    assign up_ring      = vf_req && vf_we && vf_sel == 2'd0 && vf_fn < LIMIT;
    assign pf_stat_wr   = pf_req && pf_we && pf_sel == 2'd2;
    assign pf_clear_all = pf_stat_wr && (&pf_wdata[NUM_FN-1:0]);
    assign pf_stat_rd   = pf_req && !pf_we && pf_sel == 2'd2;
    assign pf_oor_rd    = pf_req && !pf_we && pf_sel != 2'd2 && pf_fn >= LIMIT;

    always_comb begin
        dn_hot     = '0;
        vf_own_clr = '0;
        for (int i = 0; i < NUM_FN; i++) begin
            dn_hot[i]     = pf_req && pf_we && pf_sel == 2'd0 && pf_fn == FNW'(i);
            vf_own_clr[i] = vf_req && vf_we && vf_sel == 2'd2 && vf_wdata[0] && vf_fn == FNW'(i);
        end
    end

    assert_bell_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        up_ring |=> pf_irq);

    assert_data_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_irq && !up_ring) |=> !pf_irq);

    assert_stat_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pf_stat_rd |=> pf_rdata[DW-1:NUM_FN] == '0);

    assert_clear_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_clear_all && !up_ring) |=> !pf_irq);

    assert_read_no_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_stat_wr && !up_ring) |=> pf_irq == $past(pf_irq));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((dn_hot & vf_own_clr) != '0) |=> (vf_irq & $past(dn_hot)) == $past(dn_hot));

    assert_vf_bell_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_hot != '0) |=> (vf_irq & $past(dn_hot)) == $past(dn_hot));

    assert_range_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pf_oor_rd |=> pf_rdata == '0);
endmodule

bind doorbell_mailbox_bank mbx_bank_chk #(.NUM_FN(NUM_FN), .DW(DW), .FNW(FNW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pf_req(pf_req), .pf_we(pf_we), .pf_fn(pf_fn),
    .pf_sel(pf_sel), .pf_wdata(pf_wdata), .pf_rdata(pf_rdata), .pf_irq(pf_irq),
    .vf_req(vf_req), .vf_we(vf_we), .vf_fn(vf_fn), .vf_sel(vf_sel),
    .vf_wdata(vf_wdata), .vf_irq(vf_irq)
);

// File: tb/doorbell_mailbox_bank_tb.sv
`timescale 1ns/1ps
module doorbell_mailbox_bank_tb;
    localparam int N   = 16;
    localparam int DW  = 64;
    localparam int FNW = $clog2(N) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pf_req = 0, pf_we = 0, vf_req = 0, vf_we = 0;
    logic [FNW-1:0] pf_fn = '0, vf_fn = '0;
    logic [1:0] pf_sel = '0, vf_sel = '0;
    logic [DW-1:0] pf_wdata = '0, vf_wdata = '0;
    logic [DW-1:0] pf_rdata, vf_rdata;
    logic pf_irq;
    logic [N-1:0] vf_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [DW-1:0] m_up_msg [N], m_up_dat [N], m_dn_msg [N], m_dn_dat [N];
    logic [N-1:0]  m_stat, m_bell;
    logic [DW-1:0] m_pf_rd, m_vf_rd;

    always #10 clk = ~clk;

    doorbell_mailbox_bank #(.NUM_FN(N), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pf_req(pf_req), .pf_we(pf_we), .pf_fn(pf_fn), .pf_sel(pf_sel),
        .pf_wdata(pf_wdata), .pf_rdata(pf_rdata), .pf_irq(pf_irq),
        .vf_req(vf_req), .vf_we(vf_we), .vf_fn(vf_fn), .vf_sel(vf_sel),
        .vf_wdata(vf_wdata), .vf_rdata(vf_rdata), .vf_irq(vf_irq)
    );

    task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_up_msg[i] = '0; m_up_dat[i] = '0; m_dn_msg[i] = '0; m_dn_dat[i] = '0;
        end
        m_stat = '0; m_bell = '0; m_pf_rd = '0; m_vf_rd = '0;
    endtask

    task automatic idle();
        pf_req = 0; pf_we = 0; vf_req = 0; vf_we = 0;
    endtask

    task automatic pf_op(logic we, int fn, int sel, logic [DW-1:0] d);
        pf_req = 1; pf_we = we; pf_fn = FNW'(fn); pf_sel = 2'(sel); pf_wdata = d;
    endtask

    task automatic vf_op(logic we, int fn, int sel, logic [DW-1:0] d);
        vf_req = 1; vf_we = we; vf_fn = FNW'(fn); vf_sel = 2'(sel); vf_wdata = d;
    endtask

    // One clock: reference model update, edge, compare, then idle inputs
    task automatic step(string tag);
        logic [N-1:0] vset, vclr, pset, pclr;
        int pf_i, vf_i;
        pf_i = int'(pf_fn); vf_i = int'(vf_fn);
        vset = '0; vclr = '0; pset = '0; pclr = '0;
        if (pf_req && !pf_we) begin
            case (pf_sel)
                2'd0: m_pf_rd = (pf_i < N) ? m_up_msg[pf_i] : '0;
                2'd1: m_pf_rd = (pf_i < N) ? m_up_dat[pf_i] : '0;
                2'd2: m_pf_rd = DW'(m_stat);
                default: m_pf_rd = '0;
            endcase
        end
        if (vf_req && !vf_we) begin
            case (vf_sel)
                2'd0: m_vf_rd = (vf_i < N) ? m_dn_msg[vf_i] : '0;
                2'd1: m_vf_rd = (vf_i < N) ? m_dn_dat[vf_i] : '0;
                2'd2: m_vf_rd = (vf_i < N) ? DW'(m_bell[vf_i]) : '0;
                default: m_vf_rd = '0;
            endcase
        end
        if (vf_req && vf_we && vf_i < N) begin
            case (vf_sel)
                2'd0: begin m_up_msg[vf_i] = vf_wdata; vset[vf_i] = 1'b1; end
                2'd1: m_up_dat[vf_i] = vf_wdata;
                2'd2: if (vf_wdata[0]) vclr[vf_i] = 1'b1;
                default: ;
            endcase
        end
        if (pf_req && pf_we) begin
            if (pf_sel == 2'd2) pclr = pf_wdata[N-1:0];
            else if (pf_i < N && pf_sel == 2'd0) begin m_dn_msg[pf_i] = pf_wdata; pset[pf_i] = 1'b1; end
            else if (pf_i < N && pf_sel == 2'd1) m_dn_dat[pf_i] = pf_wdata;
        end
        m_stat = (m_stat & ~pclr) | vset;
        m_bell = (m_bell & ~vclr) | pset;
        @(posedge clk);
        #5;
        chk(tag, "pf_rdata", pf_rdata, m_pf_rd);
        chk(tag, "vf_rdata", vf_rdata, m_vf_rd);
        chk(tag, "pf_irq R6", DW'(pf_irq), DW'(|m_stat));
        chk(tag, "vf_irq R9", DW'(vf_irq), DW'(m_bell));
        idle();
    endtask

    initial begin
        #4ms;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        idle();
        repeat (3) @(posedge clk);
        #5;
        rst_n = 1'b1;
        chk("R1 reset", "pf_rdata", pf_rdata, '0);
        chk("R1 reset", "vf_rdata", vf_rdata, '0);
        chk("R6 reset", "pf_irq", DW'(pf_irq), '0);
        chk("R9 reset", "vf_irq", DW'(vf_irq), '0);

        vf_op(1, 3, 1, 64'hDEAD_BEEF_0000_0003); step("R3 data word no doorbell");
        step("R3 idle after data");
        vf_op(1, 3, 0, 64'h0000_0000_0000_0011); step("R2 message word rings");
        pf_op(0, 0, 2, '0);                      step("R4 status read");
        pf_op(0, 3, 1, '0);                      step("R1 read data word");
        pf_op(0, 3, 0, '0); vf_op(0, 3, 0, '0);  step("R7 reads leave status");
        vf_op(1, 7, 0, 64'h22);                  step("R2 second sender");
        pf_op(1, 9, 2, 64'h0000_0000_0000_0008); step("R5 clear bit 3 only");
        pf_op(0, 0, 2, '0);                      step("R5 status after partial clear");
        vf_op(1, 7, 0, 64'h33); pf_op(1, 0, 2, 64'h80); step("R8 set beats clear");
        pf_op(0, 0, 2, '0);                      step("R8 status keeps bit 7");
        pf_op(1, 0, 2, 64'hFFFF_FFFF_FFFF_FFFF); step("R6 clear all drops irq");
        pf_op(1, 5, 1, 64'hABCD);                step("R3 pf data no bell");
        pf_op(1, 5, 0, 64'h44);                  step("R9 pf message rings vf");
        vf_op(0, 5, 2, '0);                      step("R9 vf reads own bell");
        vf_op(0, 5, 1, '0);                      step("R1 vf reads data");
        vf_op(1, 4, 2, 64'h1);                   step("R9 other vf clear no effect");
        vf_op(1, 5, 2, 64'h0);                   step("R9 clear with bit0 zero");
        pf_op(1, 5, 0, 64'h55); vf_op(1, 5, 2, 64'h1); step("R8 vf side set beats clear");
        vf_op(1, 5, 2, 64'h1);                   step("R9 vf clears own bell");
        vf_op(1, 16, 0, 64'h99);                 step("R10 out-of-range msg write");
        vf_op(1, 20, 1, 64'h98);                 step("R10 out-of-range data write");
        pf_op(0, 20, 0, '0);                     step("R10 out-of-range read");
        vf_op(1, 2, 3, 64'h77);                  step("R10 reserved select write");
        pf_op(0, 2, 3, '0); vf_op(0, 31, 0, '0); step("R10 reserved and oor reads");

        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 1) == 1)
                pf_op(1'($urandom_range(0, 1)), $urandom_range(0, 19), $urandom_range(0, 3),
                      {$urandom(), $urandom()});
            if ($urandom_range(0, 1) == 1)
                vf_op(1'($urandom_range(0, 1)), $urandom_range(0, 19), $urandom_range(0, 3),
                      {$urandom(), $urandom()});
            step("R1 R2 R5 random mix");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule